// File: doc/BRIEF.md
# Time-Triggered Compare Unit

This block sits inside a time-triggered CAN controller and holds three compare channels that watch the controller's counters. Channel 0 watches the free-running timer. Channels 1 and 2 watch the cycle counter. When a counter first becomes equal to a channel's compare value, that channel gives a single-cycle match pulse and sets a sticky flag. Software clears the flag by writing a one to its bit.

Two channels also act on the rest of the controller. Channel 0 can give a one-cycle timer-clear pulse when a clear-enable control bit is set. The counter logic outside this block then reads zero on the next cycle. Channel 2 can give a one-cycle transmit-cancel request that carries a programmable mailbox mask, but only while the controller is not halted. A cancel that falls during halt is dropped and is not kept for later. The counters themselves, the mailboxes and the protocol engine sit outside the block.

Software reaches the block through a simple synchronous write port with a combinational read-back. The byte offsets are: compare 0 at 0x098, compare 1 at 0x09C, compare 2 at 0x0A0, control at 0x0A4, flags at 0x0A8 and cancel mask at 0x0AC. Unmapped offsets read as zero.

Top module: `ttc_compare_unit`

## Requirements
- R1: After reset, the three compare registers read 0xFFFF, and the control, flag and cancel-mask registers read 0x0000. tmr_clr and tx_cancel are low.
- R2: Each compare register keeps and returns all 16 written bits, so a written value reads back unchanged.
- R3: match_pulse[0] compares tmr_cnt with compare 0. match_pulse[1] and match_pulse[2] compare cyc_cnt with compare 1 and compare 2. A value on the other counter never causes a match.
- R4: A match pulse is high only in the first cycle in which the counter equals the compare value. It stays low while the equality holds, and it can fire again after the equality has been broken.
- R5: Each match sets flag bit k of the flag register (bit 0 for channel 0, bit 2 for channel 2) from the next cycle on. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A match in the same cycle as a clearing write leaves the flag set.
- R6: tmr_clr is high in the same cycle as a channel 0 match only when control bit 6 is 1. Channels 1 and 2 never raise tmr_clr.
- R7: On a channel 2 match with halted low, tx_cancel is high for that cycle and tx_cancel_mask equals the cancel-mask register. With halted high the request is dropped, but flag bit 2 is still set. Outside a request, tx_cancel_mask is zero, and channels 0 and 1 never raise tx_cancel.
- R8: A write to a compare register does not affect the match in the cycle of the write. From the next cycle on, the match uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| tmr_cnt | input | 16 | Free-running timer value |
| cyc_cnt | input | 16 | Cycle counter value |
| halted | input | 1 | Controller is in halt |
| match_pulse | output | 3 | Per-channel first-equality pulse |
| tmr_clr | output | 1 | Timer-clear request pulse |
| tx_cancel | output | 1 | Transmit-cancel request pulse |
| tx_cancel_mask | output | 16 | Mailboxes to cancel, zero when idle |

## Verification
A software clear of the flag register and a new match can fall on the same clock edge. The bench provokes this by writing all ones to the flag register in the same cycle in which cyc_cnt first equals compare 1, with flag 0 set beforehand. On read-back, flag 0 must be cleared and flag 1 must still be set. The bench also lines up a compare write with a counter that already equals the new value, and checks that the match appears exactly one cycle later.

// File: rtl/ttc_cmp_pkg.sv
package ttc_cmp_pkg;

   localparam int NUM_CH = 3;

   typedef enum logic [0:0] {
      SRC_TIMER = 1'b0,
      SRC_CYCLE = 1'b1
   } cmp_src_e;

   // byte offsets of the register window
   localparam int OFS_CMP_BASE = 'h098;
   localparam int OFS_CMP_STEP = 4;
   localparam int OFS_CTRL     = 'h0A4;
   localparam int OFS_FLAGS    = 'h0A8;
   localparam int OFS_MASK     = 'h0AC;

   // channel 0 follows the timer, the rest follow the cycle counter
   function automatic cmp_src_e ch_source(input int ch);
      return (ch == 0) ? SRC_TIMER : SRC_CYCLE;
   endfunction

endpackage

// File: rtl/ttc_cmp_channel.sv
module ttc_cmp_channel
   import ttc_cmp_pkg::*;
#(
   parameter int       WIDTH = 16,
   parameter cmp_src_e SRC   = SRC_TIMER
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] tmr_cnt,
   input  logic [WIDTH-1:0] cyc_cnt,
   input  logic [WIDTH-1:0] cmp_val,
   output logic             hit
);

   logic [WIDTH-1:0] watched;
   logic             eq_now;
   logic             eq_q;

   generate
      if (SRC == SRC_TIMER) begin : g_tmr
         assign watched = tmr_cnt;
         logic unused_cyc;
         assign unused_cyc = ^cyc_cnt;
      end else begin : g_cyc
         assign watched = cyc_cnt;
         logic unused_tmr;
         assign unused_tmr = ^tmr_cnt;
      end
   endgenerate

   assign eq_now = (watched == cmp_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) eq_q <= 1'b0;
      else        eq_q <= eq_now;
   end

   // only the first equal cycle counts
   assign hit = eq_now & ~eq_q;

endmodule

// File: rtl/ttc_cmp_regs.sv
module ttc_cmp_regs
   import ttc_cmp_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 8,
   parameter int MB_N    = 16,
   parameter int CLR_BIT = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [DATA_W-1:0]             wdata,
   output logic [DATA_W-1:0]             rdata,
   input  logic [NUM_CH-1:0]             match,
   output logic [NUM_CH-1:0][DATA_W-1:0] cmp_val,
   output logic                          clr_en,
   output logic [MB_N-1:0]               cancel_mask,
   output logic [NUM_CH-1:0]             flags
);

   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
   localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(OFS_FLAGS);
   localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);

   logic [NUM_CH-1:0] clr_req;

   generate
      for (genvar k = 0; k < NUM_CH; k++) begin : g_cmp
         localparam logic [ADDR_W-1:0] A_CMP = ADDR_W'(OFS_CMP_BASE + k * OFS_CMP_STEP);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      cmp_val[k] <= '1;
            else if (wr_en && addr == A_CMP) cmp_val[k] <= wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clr_en      <= 1'b0;
         cancel_mask <= '0;
      end else if (wr_en) begin
         if (addr == A_CTRL) clr_en      <= wdata[CLR_BIT];
         if (addr == A_MASK) cancel_mask <= wdata[MB_N-1:0];
      end
   end

   assign clr_req = (wr_en && addr == A_FLAGS) ? wdata[NUM_CH-1:0] : '0;

   // a new match wins over a clearing write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~clr_req) | match;
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NUM_CH; k++) begin
         if (addr == ADDR_W'(OFS_CMP_BASE + k * OFS_CMP_STEP)) rdata = cmp_val[k];
      end
      if (addr == A_CTRL)  rdata = DATA_W'(clr_en) << CLR_BIT;
      if (addr == A_FLAGS) rdata = DATA_W'(flags);
      if (addr == A_MASK)  rdata = DATA_W'(cancel_mask);
   end

endmodule

// File: rtl/ttc_cmp_action.sv
module ttc_cmp_action
   import ttc_cmp_pkg::*;
#(
   parameter int MB_N      = 16,
   parameter int CLR_CH    = 0,
   parameter int CANCEL_CH = 2
) (
   input  logic [NUM_CH-1:0] match,
   input  logic              clr_en,
   input  logic              halted,
   input  logic [MB_N-1:0]   cancel_mask,
   output logic              tmr_clr,
   output logic              tx_cancel,
   output logic [MB_N-1:0]   tx_cancel_mask
);

   assign tmr_clr        = match[CLR_CH] & clr_en;
   assign tx_cancel      = match[CANCEL_CH] & ~halted;
   assign tx_cancel_mask = tx_cancel ? cancel_mask : '0;

endmodule

// File: rtl/ttc_compare_unit.sv
module ttc_compare_unit
   import ttc_cmp_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 8,
   parameter int MB_N    = 16,
   parameter int CLR_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [DATA_W-1:0] tmr_cnt,
   input  logic [DATA_W-1:0] cyc_cnt,
   input  logic              halted,
   output logic [NUM_CH-1:0] match_pulse,
   output logic              tmr_clr,
   output logic              tx_cancel,
   output logic [MB_N-1:0]   tx_cancel_mask
);

   generate
      if (MB_N > DATA_W || MB_N < 1) begin : g_bad_mb
         $error("MB_N must lie in 1..DATA_W");
      end
      if (CLR_BIT >= DATA_W) begin : g_bad_bit
         $error("CLR_BIT outside data word");
      end
      if ((2 ** ADDR_W) <= OFS_MASK) begin : g_bad_addr
         $error("ADDR_W too small for register window");
      end
   endgenerate

   logic [NUM_CH-1:0][DATA_W-1:0] cmp_val;
   logic                          clr_en;
   logic [MB_N-1:0]               cancel_mask;
   logic [NUM_CH-1:0]             flags;

   ttc_cmp_regs #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .MB_N   (MB_N),
      .CLR_BIT(CLR_BIT)
   ) i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr),
      .addr       (reg_addr),
      .wdata      (reg_wdata),
      .rdata      (reg_rdata),
      .match      (match_pulse),
      .cmp_val    (cmp_val),
      .clr_en     (clr_en),
      .cancel_mask(cancel_mask),
      .flags      (flags)
   );

   generate
      for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
         ttc_cmp_channel #(
            .WIDTH(DATA_W),
            .SRC  (ch_source(k))
         ) i_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .tmr_cnt(tmr_cnt),
            .cyc_cnt(cyc_cnt),
            .cmp_val(cmp_val[k]),
            .hit    (match_pulse[k])
         );
      end
   endgenerate

   ttc_cmp_action #(
      .MB_N     (MB_N),
      .CLR_CH   (0),
      .CANCEL_CH(2)
   ) i_act (
      .match         (match_pulse),
      .clr_en        (clr_en),
      .halted        (halted),
      .cancel_mask   (cancel_mask),
      .tmr_clr       (tmr_clr),
      .tx_cancel     (tx_cancel),
      .tx_cancel_mask(tx_cancel_mask)
   );

endmodule

// File: rtl/ttc_cmp_checker.sv
module ttc_cmp_checker
   import ttc_cmp_pkg::*;
#(
   parameter int MB_N = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              halted,
   input logic [NUM_CH-1:0] match_pulse,
   input logic [NUM_CH-1:0] flags,
   input logic              tmr_clr,
   input logic              tx_cancel,
   input logic [MB_N-1:0]   tx_cancel_mask
);

   AST_CLEAR_FROM_CH0: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_clr |-> match_pulse[0]); // R6

   AST_CANCEL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      tx_cancel |-> (match_pulse[2] && !halted)); // R7

   AST_MASK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_cancel |-> (tx_cancel_mask == '0)); // R7

   generate
      for (genvar k = 0; k < NUM_CH; k++) begin : g_ast
         AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            match_pulse[k] |=> !match_pulse[k]); // R4

         AST_FLAG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            match_pulse[k] |=> flags[k]); // R5
      end
   endgenerate

endmodule

bind ttc_compare_unit ttc_cmp_checker #(.MB_N(MB_N)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .halted        (halted),
   .match_pulse   (match_pulse),
   .flags         (flags),
   .tmr_clr       (tmr_clr),
   .tx_cancel     (tx_cancel),
   .tx_cancel_mask(tx_cancel_mask)
);

// File: tb/test_ttc_compare_unit.sv
`timescale 1ns/1ps
module test_ttc_compare_unit;

   localparam logic [7:0] A_CMP0  = 8'h98;
   localparam logic [7:0] A_CMP1  = 8'h9C;
   localparam logic [7:0] A_CMP2  = 8'hA0;
   localparam logic [7:0] A_CTRL  = 8'hA4;
   localparam logic [7:0] A_FLAGS = 8'hA8;
   localparam logic [7:0] A_MASK  = 8'hAC;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [15:0] tmr_cnt = '0;
   logic [15:0] cyc_cnt = '0;
   logic        halted = 1'b0;
   logic [2:0]  match_pulse;
   logic        tmr_clr;
   logic        tx_cancel;
   logic [15:0] tx_cancel_mask;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   ttc_compare_unit i_ttc_compare_unit (
      .clk           (clk),
      .rst_n         (rst_n),
      .reg_wr        (reg_wr),
      .reg_addr      (reg_addr),
      .reg_wdata     (reg_wdata),
      .reg_rdata     (reg_rdata),
      .tmr_cnt       (tmr_cnt),
      .cyc_cnt       (cyc_cnt),
      .halted        (halted),
      .match_pulse   (match_pulse),
      .tmr_clr       (tmr_clr),
      .tx_cancel     (tx_cancel),
      .tx_cancel_mask(tx_cancel_mask)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic step(input logic [15:0] t, input logic [15:0] c);
      @(negedge clk);
      tmr_cnt = t; cyc_cnt = c;
      #1;
   endtask

   task automatic t_reset();
      logic [15:0] d;
      @(negedge clk);
      rd(A_CMP0, d);  chk("R1", "cmp0 reset", d, 16'hFFFF);
      rd(A_CMP1, d);  chk("R1", "cmp1 reset", d, 16'hFFFF);
      rd(A_CMP2, d);  chk("R1", "cmp2 reset", d, 16'hFFFF);
      rd(A_CTRL, d);  chk("R1", "ctrl reset", d, 16'h0000);
      rd(A_FLAGS, d); chk("R1", "flags reset", d, 16'h0000);
      rd(A_MASK, d);  chk("R1", "mask reset", d, 16'h0000);
      chk("R1", "tmr_clr reset", tmr_clr, 1'b0);
      chk("R1", "tx_cancel reset", tx_cancel, 1'b0);
   endtask

   task automatic t_regrw();
      logic [15:0] d;
      wr(A_CMP0, 16'hA5C3); rd(A_CMP0, d); chk("R2", "cmp0 readback", d, 16'hA5C3);
      wr(A_CMP2, 16'h3C5A); rd(A_CMP2, d); chk("R2", "cmp2 readback", d, 16'h3C5A);
      wr(A_CMP1, 16'h8001); rd(A_CMP1, d); chk("R2", "cmp1 readback", d, 16'h8001);
      wr(A_CMP0, 16'h0100);
      wr(A_CMP1, 16'h0200);
      wr(A_CMP2, 16'h0300);
   endtask

   task automatic t_source();
      step(16'h0200, 16'h0100); chk("R3", "cross values", match_pulse, 3'b000);
      step(16'h0100, 16'h0000); chk("R3", "timer hits ch0", match_pulse, 3'b001);
      step(16'h0000, 16'h0200); chk("R3", "cycle hits ch1", match_pulse, 3'b010);
      step(16'h0300, 16'h0300); chk("R3", "cycle hits ch2 only", match_pulse, 3'b100);
      step(16'h0000, 16'h0000);
   endtask

   task automatic t_pulse();
      step(16'h0100, 16'h0000); chk("R4", "first equal", match_pulse[0], 1'b1);
      step(16'h0100, 16'h0000); chk("R4", "held equal", match_pulse[0], 1'b0);
      step(16'h0100, 16'h0000); chk("R4", "still held", match_pulse[0], 1'b0);
      step(16'h0000, 16'h0000);
      step(16'h0100, 16'h0000); chk("R4", "re-armed", match_pulse[0], 1'b1);
      step(16'h0000, 16'h0000);
   endtask

   task automatic t_flags();
      logic [15:0] d;
      @(negedge clk);
      rd(A_FLAGS, d); chk("R5", "sticky flags", d, 16'h0007);
      wr(A_FLAGS, 16'h0002); rd(A_FLAGS, d); chk("R5", "w1c bit1", d, 16'h0005);
      wr(A_FLAGS, 16'h0000); rd(A_FLAGS, d); chk("R5", "write zero", d, 16'h0005);
      wr(A_FLAGS, 16'h0005); rd(A_FLAGS, d); chk("R5", "w1c rest", d, 16'h0000);
   endtask

   task automatic t_clear();
      logic [15:0] d;
      wr(A_CTRL, 16'h0000);
      step(16'h0100, 16'h0000);
      chk("R6", "match without enable", match_pulse[0], 1'b1);
      chk("R6", "no clear when disabled", tmr_clr, 1'b0);
      step(16'h0000, 16'h0000);
      wr(A_CTRL, 16'h0040); rd(A_CTRL, d); chk("R6", "ctrl readback", d, 16'h0040);
      step(16'h0100, 16'h0000); chk("R6", "clear on ch0 match", tmr_clr, 1'b1);
      step(16'h0000, 16'h0000); chk("R6", "clear one cycle", tmr_clr, 1'b0);
      step(16'h0000, 16'h0200); chk("R6", "ch1 no clear", tmr_clr, 1'b0);
      step(16'h0000, 16'h0000);
      wr(A_FLAGS, 16'h0007);
   endtask

   task automatic t_cancel();
      logic [15:0] d;
      wr(A_MASK, 16'h00F0);
      halted = 1'b0;
      step(16'h0000, 16'h0300);
      chk("R7", "cancel raised", tx_cancel, 1'b1);
      chk("R7", "cancel mask", tx_cancel_mask, 16'h00F0);
      step(16'h0000, 16'h0000);
      chk("R7", "cancel one cycle", tx_cancel, 1'b0);
      chk("R7", "mask idle", tx_cancel_mask, 16'h0000);
      step(16'h0100, 16'h0200); chk("R7", "ch0/ch1 no cancel", tx_cancel, 1'b0);
      step(16'h0000, 16'h0000);
      wr(A_FLAGS, 16'h0007);
      halted = 1'b1;
      step(16'h0000, 16'h0300);
      chk("R7", "halt match seen", match_pulse[2], 1'b1);
      chk("R7", "halt drops cancel", tx_cancel, 1'b0);
      chk("R7", "halt mask zero", tx_cancel_mask, 16'h0000);
      step(16'h0000, 16'h0000);
      halted = 1'b0;
      chk("R7", "not deferred", tx_cancel, 1'b0);
      rd(A_FLAGS, d); chk("R7", "flag2 under halt", d, 16'h0004);
      wr(A_FLAGS, 16'h0007);
   endtask

   task automatic t_write_timing();
      step(16'h0000, 16'h0555); chk("R8", "old value no match", match_pulse[1], 1'b0);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = A_CMP1; reg_wdata = 16'h0555;
      #1;
      chk("R8", "write cycle no match", match_pulse[1], 1'b0);
      @(negedge clk);
      reg_wr = 1'b0;
      #1;
      chk("R8", "match next cycle", match_pulse[1], 1'b1);
      step(16'h0000, 16'h0000);
   endtask

   task automatic t_collision();
      logic [15:0] d;
      wr(A_FLAGS, 16'h0007);
      step(16'h0100, 16'h0000);
      step(16'h0000, 16'h0000);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = A_FLAGS; reg_wdata = 16'h0007;
      cyc_cnt = 16'h0555;
      #1;
      chk("R5", "collision match", match_pulse[1], 1'b1);
      @(negedge clk);
      reg_wr = 1'b0;
      cyc_cnt = 16'h0000;
      rd(A_FLAGS, d); chk("R5", "set wins over clear", d, 16'h0002);
   endtask

   task automatic run_all();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_regrw();
      t_source();
      t_pulse();
      t_flags();
      t_clear();
      t_cancel();
      t_write_timing();
      t_collision();
      repeat (2) @(negedge clk);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (100000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule